// File: doc/BRIEF.md
# Operand-Tracking Computation Unit Manager

This block supervises one operation at a time on its way from the issue stage through a variable-latency ALU and back to the register file. A one-cycle issue strobe latches the operation fields and raises busy. The block then asks the register file for each needed source operand over its own request/grant pair. Operands that an operation does not need are never requested, and a fixed value is used in their place. Once every needed operand is held, the block offers the operands to the ALU over a valid/ready pair. It then captures the ALU result and asks for a result write over a second request/grant pair.

Busy stays high from the cycle after issue until the write grant arrives, so a scheduler can treat busy as the exact life of the operation. Grants can come in any order, after any delay, or in the same cycle as their request, and the block still loses no operand and uses none twice.

Top module: `compute_unit_mgr`

## Requirements
- R1: `busyO` goes high in the cycle after `issueI` is sampled high while idle. It stays high until the cycle after `wrReqO && wrGrantI`, and then goes low.
- R2: An `issueI` pulse while `busyO` is high is ignored: it starts no new operation and produces no extra write.
- R3: The operation fields (`insnTypeI`, `invertAI`, `immDataI`, `immOkI`, `zeroAI`) are latched on the accepted issue cycle. Changes to them afterwards have no effect on the result.
- R4: Source port 0 (operand A) and source port 1 (operand B) each raise a request `rdReqO[i]` in the cycle busy rises, unless that port is suppressed. `srcAI`/`srcBI` is captured only in a cycle where `rdReqO[i] && rdGrantI[i]`, and the request drops in the next cycle.
- R5: Grants may arrive in the same cycle as their request or any number of cycles later, in either order or together, and the result is still correct.
- R6: With `zeroAI` latched high, port 0 is never requested and operand A is taken as zero.
- R7: With `immOkI` latched high, port 1 is never requested and `immDataI` is used as operand B.
- R8: `rdMaskNI[i]=1` suppresses the request of port i and forces that operand to zero, and on port 1 this takes priority over the immediate. The mask is sampled live and is not latched.
- R9: With `invertAI` latched high, operand A is bitwise inverted after any zero substitution. For example, inverted 5 plus 2 gives 0xFFFC.
- R10: `aluInValidO` is asserted only after every non-suppressed operand has been captured, and never while any read request is high.
- R11: On `aluOutValidI && aluOutReadyO` the result is registered and `wrReqO` rises. `dataO` holds that result, and `wrReqO` stays high until the write grant.
- R12: A synchronous active-high reset clears busy, all requests and the captured operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issueI | input | 1 | Issue strobe |
| insnTypeI | input | 7 | Operation code passed to the ALU |
| invertAI | input | 1 | Invert operand A |
| immDataI | input | 16 | Immediate value for operand B |
| immOkI | input | 1 | Use immediate as operand B |
| zeroAI | input | 1 | Use zero as operand A |
| rdMaskNI | input | 2 | Live per-port "do not read" mask |
| busyO | output | 1 | Operation in flight |
| rdReqO | output | 2 | Per-port read requests |
| rdGrantI | input | 2 | Per-port read grants |
| srcAI | input | 16 | Operand A data, valid with grant 0 |
| srcBI | input | 16 | Operand B data, valid with grant 1 |
| wrReqO | output | 1 | Result write request |
| wrGrantI | input | 1 | Result write grant |
| dataO | output | 16 | Result data |
| aluInValidO | output | 1 | Operands valid to ALU |
| aluInReadyI | input | 1 | ALU accepts operands |
| aluOpAO | output | 16 | Operand A to ALU |
| aluOpBO | output | 16 | Operand B to ALU |
| aluInsnO | output | 7 | Latched operation code to ALU |
| aluOutValidI | input | 1 | ALU result valid |
| aluOutReadyO | output | 1 | Block ready for ALU result |
| aluResultI | input | 16 | ALU result |

## Verification
Two events can land in the same cycle: both read grants, and a read grant together with the rising of its own request. The bench provokes both by setting zero grant delay on both ports and a zero-latency ALU, which also puts the write grant in the cycle its request rises. In these cases each operand must be captured once, its request must drop the next cycle, and the written value must match the queue entry computed from the issued fields. Masked, zero and immediate cases are judged by counting the grants seen on each port.

// File: rtl/cu_pkg.sv
package cu_pkg;
  parameter int DATA_W = 16;
  parameter int INSN_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_ALU_IN,
    ST_ALU_OUT,
    ST_WRITE
  } cu_state_e;

  typedef struct packed {
    logic latchOp;
    logic capA;
    logic capB;
    logic capRes;
  } cu_strobe_t;
endpackage

// File: rtl/cu_ctrl.sv
module cu_ctrl
  import cu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       issueI,
  input  logic       fldZeroA,
  input  logic       fldImmOk,
  input  logic [1:0] rdMaskNI,
  input  logic [1:0] rdGrantI,
  input  logic       aluInReadyI,
  input  logic       aluOutValidI,
  input  logic       wrGrantI,
  output logic       busyO,
  output logic [1:0] rdReqO,
  output logic       aluInValidO,
  output logic       aluOutReadyO,
  output logic       wrReqO,
  output cu_strobe_t strobe
);
  localparam int NUM_SRC = 2;

  cu_state_e st, stNxt;
  logic [NUM_SRC-1:0] got, skip, cap, haveOp;

  assign skip[0] = fldZeroA | rdMaskNI[0];
  assign skip[1] = fldImmOk | rdMaskNI[1];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_port
    assign rdReqO[g] = (st == ST_READ) && !got[g] && !skip[g];
    assign cap[g]    = rdReqO[g] && rdGrantI[g];
    assign haveOp[g] = got[g] | skip[g] | cap[g];

    always_ff @(posedge clk) begin
      if (rst)                 got[g] <= 1'b0;
      else if (strobe.latchOp) got[g] <= 1'b0;
      else if (cap[g])         got[g] <= 1'b1;
    end
  end

  assign busyO        = (st != ST_IDLE);
  assign aluInValidO  = (st == ST_ALU_IN);
  assign aluOutReadyO = (st == ST_ALU_OUT);
  assign wrReqO       = (st == ST_WRITE);

  always_comb begin
    strobe         = '0;
    strobe.latchOp = (st == ST_IDLE) && issueI;
    strobe.capA    = cap[0];
    strobe.capB    = cap[1];
    strobe.capRes  = (st == ST_ALU_OUT) && aluOutValidI;
  end

  always_comb begin
    stNxt = st;
    unique case (st)
      ST_IDLE:    if (issueI) stNxt = ST_READ;
      ST_READ:    if (&haveOp) stNxt = ST_ALU_IN;
      ST_ALU_IN:  if (aluInReadyI) stNxt = ST_ALU_OUT;
      ST_ALU_OUT: if (aluOutValidI) stNxt = ST_WRITE;
      ST_WRITE:   if (wrGrantI) stNxt = ST_IDLE;
      default:    stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= stNxt;
  end
endmodule

// File: rtl/cu_datapath.sv
module cu_datapath
  import cu_pkg::*;
#(
  parameter int WIDTH = DATA_W,
  parameter int IW    = INSN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  cu_strobe_t       strobe,
  input  logic [IW-1:0]    insnTypeI,
  input  logic             invertAI,
  input  logic [WIDTH-1:0] immDataI,
  input  logic             immOkI,
  input  logic             zeroAI,
  input  logic [1:0]       rdMaskNI,
  input  logic [WIDTH-1:0] srcAI,
  input  logic [WIDTH-1:0] srcBI,
  input  logic [WIDTH-1:0] aluResultI,
  output logic             fldZeroA,
  output logic             fldImmOk,
  output logic [WIDTH-1:0] aluOpAO,
  output logic [WIDTH-1:0] aluOpBO,
  output logic [IW-1:0]    aluInsnO,
  output logic [WIDTH-1:0] dataO
);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [IW-1:0]    fldInsn;
  logic             fldInv;
  logic [WIDTH-1:0] fldImm;
  logic [WIDTH-1:0] opA, opB, resReg, aSel;

  always_ff @(posedge clk) begin
    if (rst) begin
      fldInsn  <= '0;
      fldInv   <= 1'b0;
      fldImm   <= '0;
      fldImmOk <= 1'b0;
      fldZeroA <= 1'b0;
      opA      <= '0;
      opB      <= '0;
      resReg   <= '0;
    end else begin
      if (strobe.latchOp) begin
        fldInsn  <= insnTypeI;
        fldInv   <= invertAI;
        fldImm   <= immDataI;
        fldImmOk <= immOkI;
        fldZeroA <= zeroAI;
        opA      <= '0;
        opB      <= '0;
      end else begin
        if (strobe.capA) opA <= srcAI;
        if (strobe.capB) opB <= srcBI;
      end
      if (strobe.capRes) resReg <= aluResultI;
    end
  end

  assign aSel     = (fldZeroA || rdMaskNI[0]) ? ZERO : opA;
  assign aluOpAO  = fldInv ? ~aSel : aSel;
  assign aluOpBO  = rdMaskNI[1] ? ZERO : (fldImmOk ? fldImm : opB);
  assign aluInsnO = fldInsn;
  assign dataO    = resReg;
endmodule

// File: rtl/compute_unit_mgr.sv
module compute_unit_mgr
  import cu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              issueI,
  input  logic [INSN_W-1:0] insnTypeI,
  input  logic              invertAI,
  input  logic [DATA_W-1:0] immDataI,
  input  logic              immOkI,
  input  logic              zeroAI,
  input  logic [1:0]        rdMaskNI,
  output logic              busyO,
  output logic [1:0]        rdReqO,
  input  logic [1:0]        rdGrantI,
  input  logic [DATA_W-1:0] srcAI,
  input  logic [DATA_W-1:0] srcBI,
  output logic              wrReqO,
  input  logic              wrGrantI,
  output logic [DATA_W-1:0] dataO,
  output logic              aluInValidO,
  input  logic              aluInReadyI,
  output logic [DATA_W-1:0] aluOpAO,
  output logic [DATA_W-1:0] aluOpBO,
  output logic [INSN_W-1:0] aluInsnO,
  input  logic              aluOutValidI,
  output logic              aluOutReadyO,
  input  logic [DATA_W-1:0] aluResultI
);
  cu_strobe_t strobe;
  logic fldZeroA, fldImmOk;

  cu_ctrl u_ctrl (
    .clk(clk), .rst(rst), .issueI(issueI),
    .fldZeroA(fldZeroA), .fldImmOk(fldImmOk),
    .rdMaskNI(rdMaskNI), .rdGrantI(rdGrantI),
    .aluInReadyI(aluInReadyI), .aluOutValidI(aluOutValidI),
    .wrGrantI(wrGrantI), .busyO(busyO), .rdReqO(rdReqO),
    .aluInValidO(aluInValidO), .aluOutReadyO(aluOutReadyO),
    .wrReqO(wrReqO), .strobe(strobe)
  );

  cu_datapath #(.WIDTH(DATA_W), .IW(INSN_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .insnTypeI(insnTypeI), .invertAI(invertAI), .immDataI(immDataI),
    .immOkI(immOkI), .zeroAI(zeroAI), .rdMaskNI(rdMaskNI),
    .srcAI(srcAI), .srcBI(srcBI), .aluResultI(aluResultI),
    .fldZeroA(fldZeroA), .fldImmOk(fldImmOk),
    .aluOpAO(aluOpAO), .aluOpBO(aluOpBO), .aluInsnO(aluInsnO),
    .dataO(dataO)
  );
endmodule

// File: rtl/cu_mgr_chk.sv
module cu_mgr_chk
  import cu_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              issueI,
  input logic [1:0]        rdMaskNI,
  input logic              busyO,
  input logic [1:0]        rdReqO,
  input logic [1:0]        rdGrantI,
  input logic              wrReqO,
  input logic              wrGrantI,
  input logic [DATA_W-1:0] dataO,
  input logic              aluInValidO
);
  a_r1_busy_after_issue: assert property (@(posedge clk) disable iff (rst)
    (!busyO && issueI) |=> busyO);

  a_r1_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busyO && !(wrReqO && wrGrantI)) |=> busyO);

  a_r1_busy_ends: assert property (@(posedge clk) disable iff (rst)
    (wrReqO && wrGrantI) |=> !busyO);

  a_r4_req_drop_a: assert property (@(posedge clk) disable iff (rst)
    (rdReqO[0] && rdGrantI[0]) |=> !rdReqO[0]);

  a_r4_req_drop_b: assert property (@(posedge clk) disable iff (rst)
    (rdReqO[1] && rdGrantI[1]) |=> !rdReqO[1]);

  a_r8_mask_a: assert property (@(posedge clk) disable iff (rst)
    rdMaskNI[0] |-> !rdReqO[0]);

  a_r8_mask_b: assert property (@(posedge clk) disable iff (rst)
    rdMaskNI[1] |-> !rdReqO[1]);

  a_r10_alu_after_ops: assert property (@(posedge clk) disable iff (rst)
    aluInValidO |-> (rdReqO == 2'b00));

  a_r11_write_held: assert property (@(posedge clk) disable iff (rst)
    (wrReqO && !wrGrantI) |=> (wrReqO && $stable(dataO)));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busyO |-> (rdReqO == 2'b00 && !wrReqO));
endmodule

bind compute_unit_mgr cu_mgr_chk u_chk (
  .clk(clk), .rst(rst), .issueI(issueI), .rdMaskNI(rdMaskNI),
  .busyO(busyO), .rdReqO(rdReqO), .rdGrantI(rdGrantI),
  .wrReqO(wrReqO), .wrGrantI(wrGrantI), .dataO(dataO),
  .aluInValidO(aluInValidO)
);

// File: tb/compute_unit_mgr_tb.sv
module compute_unit_mgr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issueI = 1'b0;
  logic [6:0] insnTypeI = '0;
  logic invertAI = 1'b0;
  logic [W-1:0] immDataI = '0;
  logic immOkI = 1'b0;
  logic zeroAI = 1'b0;
  logic [1:0] rdMaskNI = '0;
  logic busyO, wrReqO, aluInValidO, aluOutReadyO;
  logic [1:0] rdReqO;
  logic [1:0] rdGrantI = '0;
  logic [W-1:0] srcAI = '0, srcBI = '0;
  logic wrGrantI = 1'b0;
  logic [W-1:0] dataO, aluOpAO, aluOpBO;
  logic [6:0] aluInsnO;
  logic aluInReadyI = 1'b1;
  logic aluOutValidI = 1'b0;
  logic [W-1:0] aluResultI = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  compute_unit_mgr u_dut (
    .clk(clk), .rst(rst), .issueI(issueI), .insnTypeI(insnTypeI),
    .invertAI(invertAI), .immDataI(immDataI), .immOkI(immOkI),
    .zeroAI(zeroAI), .rdMaskNI(rdMaskNI), .busyO(busyO),
    .rdReqO(rdReqO), .rdGrantI(rdGrantI), .srcAI(srcAI), .srcBI(srcBI),
    .wrReqO(wrReqO), .wrGrantI(wrGrantI), .dataO(dataO),
    .aluInValidO(aluInValidO), .aluInReadyI(aluInReadyI),
    .aluOpAO(aluOpAO), .aluOpBO(aluOpBO), .aluInsnO(aluInsnO),
    .aluOutValidI(aluOutValidI), .aluOutReadyO(aluOutReadyO),
    .aluResultI(aluResultI)
  );

  // configuration shared with the responder process
  logic [W-1:0] srcVal [2];
  int srcDelay [2];
  int wrDelay;
  int aluLat;
  logic [W-1:0] expQ [$];

  // state owned by the responder process
  int reqCnt [2];
  int wrCnt;
  int cnt [2];
  int wrWait;
  int aluCnt;
  logic aluBusy;
  logic [W-1:0] aluA, aluB;
  logic [6:0] aluOp;
  int monChecks, monErrors;

  initial begin
    reqCnt = '{0, 0}; cnt = '{0, 0}; wrCnt = 0; wrWait = 0;
    aluCnt = 0; aluBusy = 1'b0; monChecks = 0; monErrors = 0;
    aluA = '0; aluB = '0; aluOp = '0;
  end

  // responders: register file ports, write port and ALU (test-side convention:
  // operation code 1 adds, anything else subtracts)
  always @(negedge clk) begin
    logic [W-1:0] expVal;
    if (!rst) begin
      for (int i = 0; i < 2; i++) begin
        logic granting;
        granting = 1'b0;
        if (rdGrantI[i]) rdGrantI[i] = 1'b0;
        else if (rdReqO[i]) begin
          if (cnt[i] >= srcDelay[i]) begin
            granting = 1'b1;
            rdGrantI[i] = 1'b1;
            reqCnt[i]++;
            cnt[i] = 0;
          end else cnt[i]++;
        end else cnt[i] = 0;
        if (i == 0) srcAI = granting ? srcVal[0] : 16'hDEAD;
        else        srcBI = granting ? srcVal[1] : 16'hBEEF;
      end
      if (wrGrantI) wrGrantI = 1'b0;
      else if (wrReqO) begin
        if (wrWait >= wrDelay) begin
          wrGrantI = 1'b1;
          wrWait = 0;
          wrCnt++;
          monChecks++;
          if (expQ.size() == 0) begin
            monErrors++;
            $display("FAIL R11: write of %h with no expected entry (expected none)", dataO);
          end else begin
            expVal = expQ.pop_front();
            if (dataO !== expVal) begin
              monErrors++;
              $display("FAIL R11: dataO=%h expected %h", dataO, expVal);
            end
          end
        end else wrWait++;
      end else wrWait = 0;
      if (aluOutValidI) begin
        aluOutValidI = 1'b0;
        aluBusy = 1'b0;
      end else if (aluInValidO && aluInReadyI) begin
        aluA = aluOpAO; aluB = aluOpBO; aluOp = aluInsnO;
        aluCnt = aluLat; aluBusy = 1'b1;
      end else if (aluBusy && aluOutReadyO) begin
        if (aluCnt == 0) begin
          aluOutValidI = 1'b1;
          aluResultI = (aluOp == 7'd1) ? aluA + aluB : aluA - aluB;
        end else aluCnt--;
      end
    end
  end

  int checks = 0;
  int errors = 0;
  logic timedOut = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: computes the expected result from the issued fields and queues it
  task automatic doIssue(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [6:0] op, input bit inv,
                         input logic [W-1:0] imm, input bit immOk,
                         input bit zA, input logic [1:0] mask,
                         input int dA, input int dB, input int dW,
                         input int lat, input bit extra);
    logic [W-1:0] ea, eb, res;
    int r0, r1, w0;
    ea = (zA || mask[0]) ? '0 : a;
    if (inv) ea = ~ea;
    eb = mask[1] ? '0 : (immOk ? imm : b);
    res = (op == 7'd1) ? ea + eb : ea - eb;
    expQ.push_back(res);
    srcVal[0] = a; srcVal[1] = b;
    srcDelay[0] = dA; srcDelay[1] = dB; wrDelay = dW; aluLat = lat;
    r0 = reqCnt[0]; r1 = reqCnt[1]; w0 = wrCnt;
    @(negedge clk);
    insnTypeI = op; invertAI = inv; immDataI = imm; immOkI = immOk;
    zeroAI = zA; rdMaskNI = mask; issueI = 1'b1;
    @(negedge clk);
    issueI = 1'b0;
    // R3: scramble the fields once the issue has been sampled
    insnTypeI = ~op; invertAI = ~inv; immDataI = ~imm; immOkI = ~immOk; zeroAI = ~zA;
    check(busyO === 1'b1, "R1", busyO, 1);
    if (extra) begin
      @(negedge clk);
      issueI = 1'b1;           // R2: issue while busy
      @(negedge clk);
      issueI = 1'b0;
    end
    while (busyO) @(negedge clk);
    rdMaskNI = 2'b00;
    check(reqCnt[0] - r0 == ((zA || mask[0]) ? 0 : 1), "R6/R8 port A grants",
          reqCnt[0] - r0, (zA || mask[0]) ? 0 : 1);
    check(reqCnt[1] - r1 == ((immOk || mask[1]) ? 0 : 1), "R7/R8 port B grants",
          reqCnt[1] - r1, (immOk || mask[1]) ? 0 : 1);
    check(wrCnt - w0 == 1, "R11 one write", wrCnt - w0, 1);
    if (extra) begin
      repeat (3) @(negedge clk);
      check(busyO === 1'b0 && wrCnt - w0 == 1, "R2 ignored issue", wrCnt - w0, 1);
    end
  endtask

  initial begin
    srcVal = '{16'h0, 16'h0}; srcDelay = '{0, 0}; wrDelay = 0; aluLat = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busyO === 1'b0 && rdReqO === 2'b00 && wrReqO === 1'b0,
              "R12 reset state", {busyO, rdReqO, wrReqO}, 0);
        // R4 plain add with delays
        doIssue(16'd5, 16'd2, 7'd1, 0, 16'd0, 0, 0, 2'b00, 1, 1, 1, 2, 0);
        // R6 R7 nothing requested
        doIssue(16'd5, 16'd2, 7'd1, 0, 16'd8, 1, 1, 2'b00, 0, 2, 0, 1, 0);
        // R7 immediate B
        doIssue(16'd5, 16'd2, 7'd1, 0, 16'd8, 1, 0, 2'b00, 2, 0, 2, 0, 0);
        // R9 invert: ~5 + 2 = FFFC
        doIssue(16'd5, 16'd2, 7'd1, 1, 16'd0, 0, 0, 2'b00, 1, 2, 0, 1, 0);
        // R6 zero A
        doIssue(16'd5, 16'd2, 7'd1, 0, 16'd0, 0, 1, 2'b00, 2, 0, 1, 0, 0);
        // R5 both grants same cycle as request, zero-latency ALU, instant write
        doIssue(16'd5, 16'd2, 7'd0, 0, 16'd0, 0, 0, 2'b00, 0, 0, 0, 0, 0);
        // R5 B before A
        doIssue(16'd40, 16'd7, 7'd0, 0, 16'd0, 0, 0, 2'b00, 4, 0, 3, 3, 0);
        // R8 masks
        doIssue(16'd5, 16'd2, 7'd1, 0, 16'd0, 0, 0, 2'b10, 2, 1, 0, 1, 0);
        doIssue(16'd5, 16'd2, 7'd1, 0, 16'd0, 0, 0, 2'b01, 1, 2, 1, 0, 0);
        doIssue(16'd5, 16'd2, 7'd1, 0, 16'd0, 0, 0, 2'b11, 1, 2, 1, 2, 0);
        // R8 mask wins over immediate on port B
        doIssue(16'd9, 16'd2, 7'd1, 0, 16'd8, 1, 0, 2'b10, 0, 0, 0, 0, 0);
        // R9 invert on a zero A gives all ones; R10 ALU after capture
        doIssue(16'd5, 16'd3, 7'd1, 1, 16'd0, 0, 1, 2'b00, 0, 3, 0, 0, 0);
        // R2 R3 issue pulse while busy
        doIssue(16'd100, 16'd1, 7'd0, 0, 16'd0, 0, 0, 2'b00, 3, 3, 2, 2, 1);
        repeat (4) @(negedge clk);
        check(expQ.size() == 0, "R11 all results written", expQ.size(), 0);
      end
      begin
        repeat (WATCHDOG) @(negedge clk);
        timedOut = 1'b1;
      end
    join_any
    if (timedOut) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors + monErrors, checks + monChecks);
    $finish;
  end
endmodule